// File: doc/BRIEF.md
# Masked Bit-Stream Width Packer

This block gathers narrow, possibly partial input beats and emits them as full-width output words. Each input beat carries an `IN_W`-bit data field and a mask whose set bits form one contiguous run. Only the selected bits are kept. They are shifted down so they start at bit 0, then placed directly above the bits already held. Once at least `OUT_W` bits are held, the lowest `OUT_W` of them form the next output word, which carries an all-ones mask.

Both sides use valid/ready handshakes. The input side is held off only when the held bits cannot absorb another beat, even after a word that leaves in the same cycle. A flush request stops input intake and drains everything still held. The last word may be partial, with a mask that marks only its valid low bits. When nothing is left, a one-cycle completion pulse follows.

The widths are independent parameters, and `IN_W` may be larger or smaller than `OUT_W`. Packing always starts at the LSB. A design that needs MSB-first order must reverse bits on both sides.

Top module: `mskpack_top`

## Requirements
- R1: Of an accepted input beat, only the bits under the contiguous mask are added to the stream, lowest selected bit first. A beat with an all-zero mask is accepted and adds nothing.
- R2: Packing is LSB-first: the first held bit appears at `out_data_o[0]`, and newly accepted bits continue directly above the held ones with no gaps.
- R3: Storage holds `IN_W+OUT_W` bits and never overflows. Outside a flush, `in_ready_o` is high exactly when the held count, minus any word leaving in the same cycle, is at most `OUT_W`.
- R4: While `out_ready_i` is low and more than `OUT_W` bits are held, `in_ready_o` is low.
- R5: Outside a flush, `out_valid_o` is high exactly when at least `OUT_W` bits are held, and `out_mask_o` is then all ones.
- R6: While `out_valid_o` is high and `out_ready_i` is low, the next cycle still shows `out_valid_o` high with unchanged `out_data_o` and `out_mask_o`.
- R7: During a flush, `out_valid_o` is high whenever any bit is held. For `n < OUT_W` held bits, the word has `out_mask_o` with bits `n-1..0` set and all higher mask and data bits zero.
- R8: `flush_done_o` goes high for exactly one cycle, in the cycle after the clock edge at which a flush is active and the held count becomes zero. A flush with nothing held gives the pulse in the next cycle and produces no output word.
- R9: `in_ready_o` is low while `flush_i` is high or a flush is still draining.
- R10: While `rst_ni` is low, and right after it is released, `out_valid_o` and `flush_done_o` are low and `in_ready_o` is high.
- R11: With `IN_W=4` and `OUT_W=6`, full-mask beats 0x0, 0x1, 0x2 produce the words 6'h10 and then 6'h08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input beat offered |
| in_data_i | input | IN_W | Input beat data |
| in_mask_i | input | IN_W | Contiguous bit-select mask for the beat |
| in_ready_o | output | 1 | Beat can be taken this cycle |
| out_valid_o | output | 1 | Output word offered |
| out_data_o | output | OUT_W | Packed output word |
| out_mask_o | output | OUT_W | Valid bits of the output word |
| out_ready_i | input | 1 | Consumer takes the word this cycle |
| flush_i | input | 1 | Request to drain all held bits |
| flush_done_o | output | 1 | One-cycle pulse when a flush has finished |

## Verification
On every cycle, the assertions check the properties that hold locally. Output words stay stable under back-pressure. The output mask is all ones outside a flush and always a low-aligned run. Input is refused while a flush is active or while the stalled store is too full, and the held count stays within the storage. The completion pulse only follows an active flush and never comes with a pending word. The bit-exact content of each word, how masked beats join across word boundaries, and the exact cycle of the completion pulse can only be shown by the bench. It compares them against a bit-queue model across random beat masks, stalls and flushes, plus the directed sequences.

// File: rtl/mskpack_pkg.sv
package mskpack_pkg;

   // flush sequencer states
   typedef enum logic {
      FL_IDLE  = 1'b0,
      FL_DRAIN = 1'b1
   } flush_st_e;

   // width of a counter able to hold 0..max_val
   function automatic int cnt_width(input int max_val);
      return $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/mskpack_align.sv
// Extracts the masked bits of one beat and right-justifies them.
module mskpack_align #(
   parameter int IN_W = 4,
   parameter int CW   = 4
) (
   input  logic [IN_W-1:0] data_i,
   input  logic [IN_W-1:0] mask_i,
   output logic [IN_W-1:0] bits_o,
   output logic [CW-1:0]   nbits_o
);

   if (IN_W == 1) begin : g_single
      assign bits_o  = data_i & mask_i;
      assign nbits_o = CW'(mask_i);
   end else begin : g_multi
      localparam int LW = $clog2(IN_W);
      logic [LW-1:0] lo_pos;
      logic [CW-1:0] ones;

      always_comb begin
         lo_pos = '0;
         for (int i = IN_W - 1; i >= 0; i--) begin
            if (mask_i[i]) lo_pos = LW'(i);
         end
      end

      always_comb begin
         ones = '0;
         for (int i = 0; i < IN_W; i++) begin
            ones = ones + CW'(mask_i[i]);
         end
      end

      assign bits_o  = (data_i & mask_i) >> lo_pos;
      assign nbits_o = ones;
   end

endmodule

// File: rtl/mskpack_store.sv
// Bit accumulator: drains OUT_W bits from the bottom, appends beats on top.
module mskpack_store #(
   parameter int IN_W  = 4,
   parameter int OUT_W = 6,
   parameter int W     = IN_W + OUT_W,
   parameter int CW    = 4
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            acc_i,
   input  logic [IN_W-1:0] beat_i,
   input  logic [CW-1:0]   nbits_i,
   input  logic            drain_i,
   output logic [W-1:0]    stor_o,
   output logic [CW-1:0]   cnt_o,
   output logic [CW-1:0]   cnt_nxt_o,
   output logic            room_o
);

   localparam logic [CW-1:0] OUT_CNT = CW'(OUT_W);

   logic [W-1:0]  stor_q, stor_dr, stor_nxt;
   logic [CW-1:0] cnt_q, cnt_dr, cnt_nxt;

   always_comb begin
      if (drain_i) begin
         stor_dr = stor_q >> OUT_W;
         cnt_dr  = (cnt_q > OUT_CNT) ? (cnt_q - OUT_CNT) : '0;
      end else begin
         stor_dr = stor_q;
         cnt_dr  = cnt_q;
      end
   end

   always_comb begin
      stor_nxt = stor_dr;
      cnt_nxt  = cnt_dr;
      if (acc_i) begin
         stor_nxt = stor_dr | (W'(beat_i) << cnt_dr);
         cnt_nxt  = cnt_dr + nbits_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stor_q <= '0;
         cnt_q  <= '0;
      end else begin
         stor_q <= stor_nxt;
         cnt_q  <= cnt_nxt;
      end
   end

   assign stor_o    = stor_q;
   assign cnt_o     = cnt_q;
   assign cnt_nxt_o = cnt_nxt;
   assign room_o    = (cnt_dr <= OUT_CNT);

endmodule

// File: rtl/mskpack_fmt.sv
// Forms the output word, its valid-bit mask and the offer signal.
module mskpack_fmt #(
   parameter int OUT_W = 6,
   parameter int CW    = 4
) (
   input  logic [OUT_W-1:0] low_i,
   input  logic [CW-1:0]    cnt_i,
   input  logic             flush_act_i,
   output logic             valid_o,
   output logic [OUT_W-1:0] data_o,
   output logic [OUT_W-1:0] mask_o
);

   for (genvar i = 0; i < OUT_W; i++) begin : g_mask
      assign mask_o[i] = (cnt_i > CW'(i));
   end

   assign data_o  = low_i;
   assign valid_o = (cnt_i >= CW'(OUT_W)) || (flush_act_i && (cnt_i != '0));

endmodule

// File: rtl/mskpack_top.sv
module mskpack_top #(
   parameter int IN_W  = 4,
   parameter int OUT_W = 6
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             in_valid_i,
   input  logic [IN_W-1:0]  in_data_i,
   input  logic [IN_W-1:0]  in_mask_i,
   output logic             in_ready_o,
   output logic             out_valid_o,
   output logic [OUT_W-1:0] out_data_o,
   output logic [OUT_W-1:0] out_mask_o,
   input  logic             out_ready_i,
   input  logic             flush_i,
   output logic             flush_done_o
);

   import mskpack_pkg::*;

   localparam int W  = IN_W + OUT_W;
   localparam int CW = cnt_width(W);

   if (IN_W < 1) begin : g_bad_in
      $error("mskpack_top: IN_W must be at least 1");
   end
   if (OUT_W < 1) begin : g_bad_out
      $error("mskpack_top: OUT_W must be at least 1");
   end

   logic [IN_W-1:0] beat_bits;
   logic [CW-1:0]   beat_n;
   logic [W-1:0]    stor_q;
   logic [CW-1:0]   cnt_q, cnt_nxt;
   logic            room, drain, accept, flush_act;
   flush_st_e       fl_q;
   logic            done_q;

   mskpack_align #(.IN_W(IN_W), .CW(CW)) u_align (
      .data_i  (in_data_i),
      .mask_i  (in_mask_i),
      .bits_o  (beat_bits),
      .nbits_o (beat_n)
   );

   mskpack_store #(.IN_W(IN_W), .OUT_W(OUT_W), .W(W), .CW(CW)) u_store (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .acc_i     (accept),
      .beat_i    (beat_bits),
      .nbits_i   (beat_n),
      .drain_i   (drain),
      .stor_o    (stor_q),
      .cnt_o     (cnt_q),
      .cnt_nxt_o (cnt_nxt),
      .room_o    (room)
   );

   mskpack_fmt #(.OUT_W(OUT_W), .CW(CW)) u_fmt (
      .low_i       (stor_q[OUT_W-1:0]),
      .cnt_i       (cnt_q),
      .flush_act_i (flush_act),
      .valid_o     (out_valid_o),
      .data_o      (out_data_o),
      .mask_o      (out_mask_o)
   );

   assign flush_act  = flush_i || (fl_q == FL_DRAIN);
   assign drain      = out_valid_o && out_ready_i;
   assign in_ready_o = !flush_act && room;
   assign accept     = in_valid_i && in_ready_o;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         fl_q   <= FL_IDLE;
         done_q <= 1'b0;
      end else begin
         done_q <= flush_act && (cnt_nxt == '0);
         if (flush_act && (cnt_nxt != '0)) fl_q <= FL_DRAIN;
         else                              fl_q <= FL_IDLE;
      end
   end

   assign flush_done_o = done_q;

endmodule

// File: rtl/mskpack_chk.sv
module mskpack_chk #(
   parameter int IN_W  = 4,
   parameter int OUT_W = 6
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             in_valid_i,
   input logic [IN_W-1:0]  in_mask_i,
   input logic             in_ready_o,
   input logic             out_valid_o,
   input logic [OUT_W-1:0] out_data_o,
   input logic [OUT_W-1:0] out_mask_o,
   input logic             out_ready_i,
   input logic             flush_done_o,
   input logic             flush_act,
   input logic [$clog2(IN_W+OUT_W+1)-1:0] cnt_q
);

   localparam int CW = $clog2(IN_W + OUT_W + 1);

   // R1: accepted masks are one contiguous run (or empty)
   a_r1_mask_contig: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid_i && in_ready_o) |->
         ((in_mask_i == '0) ||
          ((((in_mask_i | (in_mask_i - IN_W'(1))) + IN_W'(1)) & in_mask_i) == '0)));

   // R3: held count never exceeds the storage
   a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= CW'(IN_W + OUT_W));

   // R4: stalled and too full means no intake
   a_r4_backpressure: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!out_ready_i && (cnt_q > CW'(OUT_W))) |-> !in_ready_o);

   // R5: full mask outside a flush
   a_r5_full_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o && !flush_act) |-> (&out_mask_o));

   // R6: offered word holds until taken
   a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o && !out_ready_i) |=>
         (out_valid_o && $stable(out_data_o) && $stable(out_mask_o)));

   // R7: output mask is a low-aligned run
   a_r7_mask_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o |-> (((out_mask_o + OUT_W'(1)) & out_mask_o) == '0));

   // R8: completion only after an active flush, and with nothing pending
   a_r8_done_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_done_o |-> $past(flush_act));
   a_r8_done_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_done_o |-> !out_valid_o);

   // R9: no intake during a flush
   a_r9_flush_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_act |-> !in_ready_o);

endmodule

bind mskpack_top mskpack_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (.*);

// File: tb/mskpack_top_bench.sv
`timescale 1ns/1ps
module mskpack_top_bench;

   localparam int IN_W  = 4;
   localparam int OUT_W = 6;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic [IN_W-1:0]  in_data = '0;
   logic [IN_W-1:0]  in_mask = '0;
   logic             in_ready;
   logic             out_valid;
   logic [OUT_W-1:0] out_data;
   logic [OUT_W-1:0] out_mask;
   logic             out_ready = 1'b0;
   logic             flush = 1'b0;
   logic             flush_done;

   always #2.5 clk = ~clk;

   mskpack_top #(.IN_W(IN_W), .OUT_W(OUT_W)) u_mskpack_top (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .in_valid_i   (in_valid),
      .in_data_i    (in_data),
      .in_mask_i    (in_mask),
      .in_ready_o   (in_ready),
      .out_valid_o  (out_valid),
      .out_data_o   (out_data),
      .out_mask_o   (out_mask),
      .out_ready_i  (out_ready),
      .flush_i      (flush),
      .flush_done_o (flush_done)
   );

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   // reference model state
   bit               mq[$];
   bit               pend = 1'b0;
   bit               exp_done = 1'b0;
   logic [OUT_W-1:0] words[$];
   bit               prev_hold = 1'b0;
   logic [OUT_W-1:0] prev_d, prev_m;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // compare outputs against the model, then advance the model
   task automatic observe();
      bit               fact;
      int               sz, pop, after;
      bit               ev, eir;
      logic [OUT_W-1:0] ed, em;
      fact = flush || pend;
      sz   = mq.size();
      ev   = (sz >= OUT_W) || (fact && sz > 0);
      for (int i = 0; i < OUT_W; i++) begin
         ed[i] = (i < sz) ? mq[i] : 1'b0;
         em[i] = (i < sz);
      end
      chk(out_valid == ev, fact ? "R7 out_valid in flush" : "R5 out_valid", 32'(out_valid), 32'(ev));
      if (ev && out_valid) begin
         chk(out_data == ed, fact ? "R7 flush data" : "R2 packed data", 32'(out_data), 32'(ed));
         chk(out_mask == em, fact ? "R7 flush mask" : "R5 full mask", 32'(out_mask), 32'(em));
      end
      if (prev_hold)
         chk(out_valid && out_data == prev_d && out_mask == prev_m, "R6 hold under stall",
             32'(out_data), 32'(prev_d));
      chk(flush_done == exp_done, "R8 flush_done", 32'(flush_done), 32'(exp_done));
      pop   = (ev && out_ready) ? ((sz < OUT_W) ? sz : OUT_W) : 0;
      after = sz - pop;
      eir   = !fact && (after <= OUT_W);
      chk(in_ready == eir,
          fact ? "R9 no intake in flush" :
          (!out_ready && sz > OUT_W) ? "R4 backpressure" : "R3 ready when room",
          32'(in_ready), 32'(eir));
      // advance model
      if (out_valid && out_ready) words.push_back(out_data);
      for (int i = 0; i < pop; i++) void'(mq.pop_front());
      if (in_valid && in_ready) begin
         for (int i = 0; i < IN_W; i++) if (in_mask[i]) mq.push_back(in_data[i]);
      end
      exp_done  = fact && (mq.size() == 0);
      pend      = fact && (mq.size() != 0);
      prev_hold = out_valid && !out_ready;
      prev_d    = out_data;
      prev_m    = out_mask;
   endtask

   task automatic step(input bit v, input logic [IN_W-1:0] d, input logic [IN_W-1:0] m,
                       input bit ordy, input bit fl);
      @(posedge clk);
      #1;
      in_valid  = v;
      in_data   = d;
      in_mask   = m;
      out_ready = ordy;
      flush     = fl;
      @(negedge clk);
      observe();
   endtask

   function automatic logic [IN_W-1:0] rand_mask();
      int len, lo;
      len = $urandom_range(IN_W, 0);
      lo  = $urandom_range(IN_W - len, 0);
      return IN_W'(((1 << len) - 1) << lo);
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int nw;
      void'($urandom(32'h5eed_0042));
      // R10: reset state
      repeat (3) @(negedge clk);
      chk(!out_valid && !flush_done && in_ready, "R10 during reset",
          {29'd0, out_valid, flush_done, in_ready}, 32'h1);
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      chk(!out_valid && !flush_done && in_ready, "R10 after reset",
          {29'd0, out_valid, flush_done, in_ready}, 32'h1);

      // R11: worked example
      step(1, 4'h0, 4'hF, 1, 0);
      step(1, 4'h1, 4'hF, 1, 0);
      step(1, 4'h2, 4'hF, 1, 0);
      step(0, 4'h0, 4'h0, 1, 0);
      step(0, 4'h0, 4'h0, 1, 0);
      chk(words.size() == 2, "R11 word count", words.size(), 2);
      if (words.size() == 2) begin
         chk(words[0] == 6'h10, "R11 first word", 32'(words[0]), 32'h10);
         chk(words[1] == 6'h08, "R11 second word", 32'(words[1]), 32'h08);
      end

      // R8: flush while empty gives a pulse and no word
      nw = words.size();
      step(0, 4'h0, 4'h0, 1, 1);
      step(0, 4'h0, 4'h0, 1, 0);
      chk(flush_done == 1'b1, "R8 empty flush pulse", 32'(flush_done), 1);
      step(0, 4'h0, 4'h0, 1, 0);
      chk(flush_done == 1'b0, "R8 pulse is one cycle", 32'(flush_done), 0);
      chk(words.size() == nw, "R8 no word on empty flush", words.size(), nw);

      // R1: misaligned partial beats and a zero-mask beat, then a stalled flush
      step(1, 4'b0100, 4'b0110, 1, 0);
      step(1, 4'b1000, 4'b1000, 1, 0);
      step(1, 4'b1111, 4'b0000, 1, 0);
      step(0, 4'h0, 4'h0, 0, 1);
      chk(out_valid && out_data == 6'h06 && out_mask == 6'h07, "R1 packed partial beats",
          {out_data, out_mask}, {6'h06, 6'h07});
      step(1, 4'hF, 4'hF, 0, 0);
      step(1, 4'hF, 4'hF, 0, 0);
      chk(!in_ready, "R9 intake blocked while draining", 32'(in_ready), 0);
      step(0, 4'h0, 4'h0, 1, 0);
      step(0, 4'h0, 4'h0, 1, 0);
      chk(words.size() == nw + 1 && words[words.size()-1] == 6'h06, "R7 flushed word",
          32'(words[words.size()-1]), 32'h06);

      // random mix
      for (int c = 0; c < 4000; c++) begin
         bit fl;
         fl = (!pend && $urandom_range(59, 0) == 0);
         step($urandom_range(3, 0) != 0, IN_W'($urandom), rand_mask(),
              $urandom_range(3, 0) != 0, fl);
      end
      // final drain
      step(0, 4'h0, 4'h0, 1, 1);
      for (int c = 0; c < 20; c++) step(0, 4'h0, 4'h0, 1, 0);
      chk(mq.size() == 0 && !out_valid, "R8 drained at end", 32'(mq.size()), 0);

      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule